// File: doc/BRIEF.md
# Display FIFO Fetch Request Scheduler

This block decides when a display pipeline asks memory for more data and how many quadwords each request carries. It watches how full the pixel FIFO is and keeps its own count of data that has been requested but has not yet come back. The way it picks request times and sizes depends on the active display mode. High-resolution mode uses a programmable low-water level and burst size. Text mode issues fixed character-line fetches and single-quadword font fetches. Graphics VGA mode trickles single quadwords whenever one slot is free.

The request leaves on a valid/ready channel. Once `req_valid_o` rises it stays high, and type and length stay frozen, until the cycle where `req_ready_i` is sampled high. That cycle counts as acceptance, and the block then drops valid for at least one cycle. Back-pressure only delays the request and never cancels it. Returned data comes back as a one-quadword-per-cycle strobe with no back-pressure. A separate strobe reports each quadword that moves from the 32-entry synchronizer stage into the display engine FIFO. From these the block tracks synchronizer occupancy and raises a sticky flag if a quadword arrives while that stage is full.

Address generation, arbitration, FIFO storage and the register interface sit outside this block.

Top module: `dfifo_req_sched`

## Requirements
- R1: After reset `req_valid_o` and `sync_ovf_o` are 0, and the active mode is high-resolution.
- R2: In high-resolution mode (mode code 0) a pixel request (type 0) of `burst_i` quadwords is raised when FIFO use plus outstanding quadwords is at or below `wm_i` and the free space (48 minus that sum) covers the whole burst.
- R3: When `wm_i` or `burst_i` is zero, `cfg_err_o` is 1 and high-resolution mode raises no request.
- R4: In text mode (code 1), while `char_need_i` is high and no character data is outstanding, a character request (type 1) of exactly 8 quadwords is raised whatever the FIFO space. It takes priority over font requests.
- R5: In text mode a font request (type 2) of 1 quadword is raised only when free FIFO space is at least 8.
- R6: In graphics VGA mode (code 2) a pixel request of 1 quadword is raised whenever free space is at least 1. Code 3 raises nothing.
- R7: While `req_valid_o` is high and `req_ready_i` low, valid, type and length hold unchanged.
- R8: An accepted pixel or font request adds its length to the outstanding count, and each returned non-character strobe removes one. No request makes FIFO use plus outstanding exceed 48.
- R9: A change on `mode_i` takes effect only in a cycle with no request pending and nothing outstanding. Until then the old mode governs.
- R10: `sync_ovf_o` sets when a non-character quadword returns while the 32-entry synchronizer stage holds 32 and none drains that cycle. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| mode_i | input | 2 | Requested mode: 0 high-res, 1 text, 2 graphics VGA, 3 off |
| wm_i | input | 6 | High-res low-water level in quadwords |
| burst_i | input | 6 | High-res request length in quadwords |
| used_i | input | 6 | Quadwords currently held across both FIFO stages |
| char_need_i | input | 1 | Character buffer wants a new line (text mode) |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted when high with valid |
| req_type_o | output | 2 | 0 pixel, 1 character, 2 font |
| req_len_o | output | 6 | Request length in quadwords |
| rd_valid_i | input | 1 | One returned quadword this cycle |
| rd_char_i | input | 1 | Returned quadword belongs to the character buffer |
| sync_drain_i | input | 1 | One quadword left the synchronizer stage |
| cfg_err_o | output | 1 | Watermark or burst programmed to zero |
| sync_ovf_o | output | 1 | Sticky synchronizer overflow |

## Verification
A wrong outstanding count is the most damaging fault. If it is too high, the ports show requests that stop early and then never come back after data returns. If it is too low, a second burst appears within two cycles of an acceptance that should have blocked it. A bad mode register shows up as request types or lengths from the wrong mode in the first request after the switch. An occupancy error in the synchronizer tracker either raises the overflow flag during a legal high-resolution setting or leaves it low on the seventeenth undrained quadword of the over-aggressive 33/32 setting.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic [1:0] {
    MODE_HIRES = 2'd0,
    MODE_TEXT  = 2'd1,
    MODE_GFX   = 2'd2,
    MODE_OFF   = 2'd3
  } dmode_e;

  typedef enum logic [1:0] {
    RT_PIXEL = 2'd0,
    RT_CHAR  = 2'd1,
    RT_FONT  = 2'd2,
    RT_NONE  = 2'd3
  } rtype_e;
endpackage

// File: rtl/dfr_policy.sv
module dfr_policy
  import dfr_pkg::*;
#(
  parameter int TOTAL_QW  = 48,
  parameter int CFG_W     = 6,
  parameter int CNT_W     = 6,
  parameter int CHAR_QW   = 8,
  parameter int FONT_ROOM = 8
) (
  input  dmode_e           mode_i,
  input  logic [CFG_W-1:0] wm_i,
  input  logic [CFG_W-1:0] burst_i,
  input  logic [CNT_W-1:0] used_i,
  input  logic [CNT_W-1:0] fifo_pend_i,
  input  logic [CNT_W-1:0] char_pend_i,
  input  logic             char_need_i,
  output logic             want_o,
  output rtype_e           kind_o,
  output logic [CFG_W-1:0] len_o,
  output logic             cfg_err_o
);
  localparam int W = ((CFG_W > CNT_W) ? CFG_W : CNT_W) + 1;

  logic [W-1:0] level, room, wm_x, burst_x;
  logic         hires_go, font_go, char_go, gfx_go;

  always_comb begin
    level   = W'(used_i) + W'(fifo_pend_i);
    room    = (level >= W'(TOTAL_QW)) ? '0 : (W'(TOTAL_QW) - level);
    wm_x    = W'(wm_i);
    burst_x = W'(burst_i);
  end

  assign cfg_err_o = (wm_i == '0) || (burst_i == '0);
  assign hires_go  = !cfg_err_o && (level <= wm_x) && (room >= burst_x);
  assign char_go   = char_need_i && (char_pend_i == '0);
  assign font_go   = room >= W'(FONT_ROOM);
  assign gfx_go    = room != '0;

  always_comb begin
    want_o = 1'b0;
    kind_o = RT_NONE;
    len_o  = '0;
    unique case (mode_i)
      MODE_HIRES: begin
        want_o = hires_go;
        kind_o = RT_PIXEL;
        len_o  = burst_i;
      end
      MODE_TEXT: begin
        if (char_go) begin
          want_o = 1'b1;
          kind_o = RT_CHAR;
          len_o  = CFG_W'(CHAR_QW);
        end else begin
          want_o = font_go;
          kind_o = RT_FONT;
          len_o  = CFG_W'(1);
        end
      end
      MODE_GFX: begin
        want_o = gfx_go;
        kind_o = RT_PIXEL;
        len_o  = CFG_W'(1);
      end
      default: begin
        want_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (want_o && mode_i == MODE_HIRES)
      a_hires_fit_r2: assert (level + burst_x <= W'(TOTAL_QW));
    if (want_o && kind_o == RT_FONT)
      a_font_room_r5: assert (room >= W'(FONT_ROOM));
  end
endmodule

// File: rtl/dfr_credit.sv
module dfr_credit
  import dfr_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int CFG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  rtype_e           acc_kind_i,
  input  logic [CFG_W-1:0] acc_len_i,
  input  logic             beat_i,
  input  logic             beat_char_i,
  output logic [CNT_W-1:0] fifo_pend_o,
  output logic [CNT_W-1:0] char_pend_o
);
  logic [CNT_W-1:0] fifo_add, char_add, fifo_sub, char_sub;

  always_comb begin
    fifo_add = (acc_i && acc_kind_i != RT_CHAR) ? CNT_W'(acc_len_i) : '0;
    char_add = (acc_i && acc_kind_i == RT_CHAR) ? CNT_W'(acc_len_i) : '0;
    fifo_sub = (beat_i && !beat_char_i) ? CNT_W'(1) : '0;
    char_sub = (beat_i &&  beat_char_i) ? CNT_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_pend_o <= '0;
      char_pend_o <= '0;
    end else begin
      fifo_pend_o <= fifo_pend_o + fifo_add - fifo_sub;
      char_pend_o <= char_pend_o + char_add - char_sub;
    end
  end

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && !beat_char_i) |-> (fifo_pend_o != '0));
  p_char_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && beat_char_i) |-> (char_pend_o != '0));
endmodule

// File: rtl/dfr_sync_mon.sv
module dfr_sync_mon #(
  parameter int SYNC_QW = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat_i,
  input  logic drain_i,
  output logic ovf_o
);
  localparam int SW = $clog2(SYNC_QW + 1);

  logic [SW-1:0] occ;
  logic          full, drain_ok;

  assign full     = occ == SW'(SYNC_QW);
  assign drain_ok = drain_i && (occ != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ   <= '0;
      ovf_o <= 1'b0;
    end else if (beat_i && !drain_ok) begin
      if (full) ovf_o <= 1'b1;
      else      occ   <= occ + SW'(1);
    end else if (!beat_i && drain_ok) begin
      occ <= occ - SW'(1);
    end
  end

  p_occ_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= SW'(SYNC_QW));
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(beat_i && full && !drain_i));
endmodule

// File: rtl/dfifo_req_sched.sv
module dfifo_req_sched
  import dfr_pkg::*;
#(
  parameter int TOTAL_QW  = 48,
  parameter int SYNC_QW   = 32,
  parameter int CFG_W     = 6,
  parameter int CHAR_QW   = 8,
  parameter int FONT_ROOM = 8,
  localparam int CNT_W    = $clog2(TOTAL_QW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [CFG_W-1:0] wm_i,
  input  logic [CFG_W-1:0] burst_i,
  input  logic [CNT_W-1:0] used_i,
  input  logic             char_need_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [1:0]       req_type_o,
  output logic [CFG_W-1:0] req_len_o,
  input  logic             rd_valid_i,
  input  logic             rd_char_i,
  input  logic             sync_drain_i,
  output logic             cfg_err_o,
  output logic             sync_ovf_o
);
  dmode_e           act_mode;
  rtype_e           kind_q, want_kind;
  logic [CFG_W-1:0] len_q, want_len;
  logic             want, accept, idle, switch_mode;
  logic [CNT_W-1:0] fifo_pend, char_pend;
  logic [CNT_W:0]   commit;

  assign accept      = req_valid_o && req_ready_i;
  assign idle        = !req_valid_o && (fifo_pend == '0) && (char_pend == '0);
  assign switch_mode = idle && (mode_i != act_mode);

  dfr_policy #(
    .TOTAL_QW (TOTAL_QW),
    .CFG_W    (CFG_W),
    .CNT_W    (CNT_W),
    .CHAR_QW  (CHAR_QW),
    .FONT_ROOM(FONT_ROOM)
  ) u_policy (
    .mode_i     (act_mode),
    .wm_i       (wm_i),
    .burst_i    (burst_i),
    .used_i     (used_i),
    .fifo_pend_i(fifo_pend),
    .char_pend_i(char_pend),
    .char_need_i(char_need_i),
    .want_o     (want),
    .kind_o     (want_kind),
    .len_o      (want_len),
    .cfg_err_o  (cfg_err_o)
  );

  dfr_credit #(
    .CNT_W(CNT_W),
    .CFG_W(CFG_W)
  ) u_credit (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_i      (accept),
    .acc_kind_i (kind_q),
    .acc_len_i  (len_q),
    .beat_i     (rd_valid_i),
    .beat_char_i(rd_char_i),
    .fifo_pend_o(fifo_pend),
    .char_pend_o(char_pend)
  );

  dfr_sync_mon #(
    .SYNC_QW(SYNC_QW)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .beat_i (rd_valid_i && !rd_char_i),
    .drain_i(sync_drain_i),
    .ovf_o  (sync_ovf_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid_o <= 1'b0;
      kind_q      <= RT_PIXEL;
      len_q       <= '0;
      act_mode    <= MODE_HIRES;
    end else if (req_valid_o) begin
      if (req_ready_i) req_valid_o <= 1'b0;
    end else if (switch_mode) begin
      act_mode <= dmode_e'(mode_i);
    end else if (want) begin
      req_valid_o <= 1'b1;
      kind_q      <= want_kind;
      len_q       <= want_len;
    end
  end

  assign req_type_o = kind_q;
  assign req_len_o  = len_q;
  assign commit     = (CNT_W+1)'(used_i) + (CNT_W+1)'(fifo_pend);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_type_o) && $stable(req_len_o)));
  p_char_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && kind_q == RT_CHAR) |-> (len_q == CFG_W'(CHAR_QW)));
  p_font_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && kind_q == RT_FONT) |-> (len_q == CFG_W'(1)));
  p_gfx_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && act_mode == MODE_GFX) |-> (len_q == CFG_W'(1) && kind_q == RT_PIXEL));
  p_cfg_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == MODE_HIRES && cfg_err_o && !req_valid_o) |=> !req_valid_o);
  p_mode_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_mode) |-> $past(!req_valid_o && fifo_pend == '0 && char_pend == '0));
  p_credit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit <= (CNT_W+1)'(TOTAL_QW));
endmodule

// File: tb/sim_dfifo_req_sched.sv
module sim_dfifo_req_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [5:0] wm = 6'd16, burst = 6'd16, used = 6'd48;
  logic       char_need = 1'b0, ready = 1'b1;
  logic       rd_valid = 1'b0, rd_char = 1'b0, drain = 1'b0;
  logic       req_valid, cfg_err, ovf;
  logic [1:0] req_type;
  logic [5:0] req_len;

  int checks = 0, fails = 0;
  int q_kind[$];
  int q_len[$];
  string q_tag[$];

  always #10 clk = ~clk;

  dfifo_req_sched u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .wm_i(wm), .burst_i(burst),
    .used_i(used), .char_need_i(char_need), .req_valid_o(req_valid),
    .req_ready_i(ready), .req_type_o(req_type), .req_len_o(req_len),
    .rd_valid_i(rd_valid), .rd_char_i(rd_char), .sync_drain_i(drain),
    .cfg_err_o(cfg_err), .sync_ovf_o(ovf)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(int k, int l, string tag);
    q_kind.push_back(k);
    q_len.push_back(l);
    q_tag.push_back(tag);
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // monitor: compares accepted requests against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && req_valid && ready) begin
      if (q_kind.size() == 0) begin
        chk(1'b0, "unexpected request", req_type * 100 + req_len, -1);
      end else begin
        int k, l;
        string t;
        k = q_kind.pop_front();
        l = q_len.pop_front();
        t = q_tag.pop_front();
        chk(req_type == k && req_len == l, t, req_type * 100 + req_len, k * 100 + l);
      end
    end
  end

  task automatic wait_empty(string tag);
    for (int i = 0; i < 400 && q_kind.size() != 0; i++) step();
    repeat (2) step();
    chk(q_kind.size() == 0, tag, q_kind.size(), 0);
  endtask

  task automatic idle_chk(int n, string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req_valid) seen++;
    end
    chk(seen == 0, tag, seen, 0);
    step();
  endtask

  task automatic beats(int n, bit ch, bit dr);
    for (int i = 0; i < n; i++) begin
      step();
      if (i > 0 && !ch) used++;
      rd_valid = 1'b1; rd_char = ch; drain = dr;
    end
    step();
    if (n > 0 && !ch) used++;
    rd_valid = 1'b0; rd_char = 1'b0; drain = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..: run did not finish actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    @(negedge clk);
    // R1: reset state
    chk(!req_valid, "R1 valid after reset", req_valid, 0);
    chk(!ovf, "R1 overflow after reset", ovf, 0);
    chk(!cfg_err, "R1 cfg_err with legal setting", cfg_err, 0);

    // R2: high-res, two 16-quadword bursts fit, then credit stops (R8)
    push(0, 16, "R2 first burst");
    push(0, 16, "R2 second burst");
    step(); used = 6'd0;
    wait_empty("R2 bursts issued");
    idle_chk(8, "R8 no request beyond outstanding credit");
    beats(32, 1'b0, 1'b1);
    idle_chk(6, "R2 level above watermark");
    chk(!ovf, "R10 no overflow under legal setting", ovf, 0);

    // R9: mode change deferred while data outstanding
    push(0, 16, "R2 refill a");
    push(0, 16, "R2 refill b");
    used = 6'd0;
    wait_empty("R2 refill issued");
    mode = 2'd2;
    idle_chk(10, "R9 old mode holds while outstanding");

    // R6: graphics trickle after switch
    for (int i = 0; i < 16; i++) push(0, 1, "R6 single quadword");
    beats(32, 1'b0, 1'b1);
    wait_empty("R6/R9 graphics after switch");
    beats(16, 1'b0, 1'b1);
    idle_chk(6, "R6 no request when full");

    // R7: hold under back-pressure
    ready = 1'b0;
    used = 6'd47;
    repeat (2) step();
    begin
      int bad = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (!(req_valid && req_type == 2'd0 && req_len == 6'd1)) bad++;
      end
      chk(bad == 0, "R7 request held stable", bad, 0);
    end
    push(0, 1, "R7 held request accepted");
    ready = 1'b1;
    wait_empty("R7 drained");
    idle_chk(5, "R6 free space exhausted");

    // R5/R4: text mode
    mode = 2'd1;
    beats(1, 1'b0, 1'b1);
    idle_chk(8, "R5 font blocked without 8 free");
    push(1, 8, "R4 character fetch with full FIFO");
    char_need = 1'b1;
    wait_empty("R4 character issued");
    char_need = 1'b0;
    used = 6'd41;
    idle_chk(6, "R5 font blocked at 7 free");
    push(2, 1, "R5 font at 8 free");
    used = 6'd40;
    wait_empty("R5 font issued");
    idle_chk(5, "R5 single font outstanding");
    beats(8, 1'b1, 1'b0);
    beats(1, 1'b0, 1'b1);
    push(1, 8, "R4 character wins over font");
    push(2, 1, "R5 font after character");
    used = 6'd40;
    char_need = 1'b1;
    wait_empty("R4 priority order");
    char_need = 1'b0;
    beats(8, 1'b1, 1'b0);
    beats(1, 1'b0, 1'b1);

    // R3: zero settings block high-res
    mode = 2'd0; wm = 6'd0; used = 6'd0;
    step();
    @(negedge clk);
    chk(cfg_err, "R3 zero watermark flagged", cfg_err, 1);
    idle_chk(10, "R3 no request with zero watermark");
    wm = 6'd16; burst = 6'd0;
    @(negedge clk);
    chk(cfg_err, "R3 zero burst flagged", cfg_err, 1);
    idle_chk(10, "R3 no request with zero burst");

    // R10: 33/32 setting overruns the synchronizer stage
    push(0, 32, "R2 first 32 burst");
    wm = 6'd33; burst = 6'd32;
    wait_empty("R2 33/32 first");
    beats(16, 1'b0, 1'b1);
    beats(16, 1'b0, 1'b0);
    @(negedge clk);
    chk(!ovf, "R10 stage not yet overrun", ovf, 0);
    push(0, 32, "R2 second 32 burst");
    used = 6'd16;
    wait_empty("R2 33/32 second");
    beats(17, 1'b0, 1'b0);
    @(negedge clk);
    chk(ovf, "R10 overflow on 17th undrained quadword", ovf, 1);
    beats(15, 1'b0, 1'b1);
    @(negedge clk);
    chk(ovf, "R10 overflow sticky", ovf, 1);
    idle_chk(5, "R8 nothing beyond capacity");

    finish_run();
  end
endmodule